// File: doc/BRIEF.md
# Cipher Self-Test Sequencer

This block decides when a pair of cipher engines (one encrypting, one decrypting) may carry live traffic. Once reset is released it starts a known-answer test without outside help. The encrypt engine gets a built-in key, tweak and plaintext, and its result must equal a built-in ciphertext. Then the decrypt engine gets that ciphertext under the same key and tweak, and its result must equal the plaintext. Service grants and engine data outputs stay shut until both results match.

Any wrong answer sets a terminal fault. So does an engine that does not answer within a fixed number of cycles. In the fault state the data outputs are held at zero, the key store is asked to clear, no further test requests go out and every service request is refused. Only a reset leaves the fault state. A single-cycle pulse on the trigger input reruns the whole sequence while the block is operating. Two level outputs report the result: one for "tests passed, operating" and one for "fault".

Top module: `cipher_selftest_seq`

## Requirements
- R1: In the first clock cycle after reset is released, the encrypt test request rises with no external action.
- R2: The decrypt test request rises only after the encrypt result has matched. The two test requests are never high together, and a failed encrypt test means no decrypt request is ever made.
- R3: While a test runs, the key and tweak outputs carry the built-in key and tweak. The data output carries the plaintext for the encrypt test and the ciphertext for the decrypt test. The expected results are the ciphertext and the plaintext respectively.
- R4: Except in the operating state, every service grant is 0 and every engine data output lane is zero. In the operating state the grants follow the service requests and the lanes pass the engine data.
- R5: A result that does not match the expected value moves the block to the fault state on the next clock. There the fault output and key-clear request are 1, the pass output is 0, both test requests are 0 and all grants and data lanes are 0.
- R6: An acknowledge counts only if it arrives in cycle TIMEOUT-1 or earlier, counting the first cycle of the request as cycle 0. If cycle TIMEOUT-1 ends with no acknowledge, the block enters the fault state on the next clock.
- R7: The fault state persists until reset, and a trigger pulse has no effect there. After a reset the sequence runs afresh.
- R8: A trigger pulse in the operating state drops the pass output and raises the encrypt request on the next clock. The full sequence then repeats.
- R9: The pass output is 1 only in the operating state and the fault output is 1 only in the fault state. During reset both are 0.
- R10: Acknowledges that arrive while no test is running are ignored, whatever result value comes with them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| selftest_trig_i | input | 1 | One-cycle pulse requesting a test rerun |
| kat_enc_req_o | output | 1 | Encrypt engine test request, held until acknowledge |
| kat_dec_req_o | output | 1 | Decrypt engine test request, held until acknowledge |
| kat_key_o | output | KEY_W | Test key while a test runs, else zero |
| kat_tweak_o | output | BLK_W | Test tweak while a test runs, else zero |
| kat_din_o | output | BLK_W | Test input block while a test runs, else zero |
| kat_enc_ack_i | input | 1 | Encrypt engine result valid |
| kat_enc_res_i | input | BLK_W | Encrypt engine result |
| kat_dec_ack_i | input | 1 | Decrypt engine result valid |
| kat_dec_res_i | input | BLK_W | Decrypt engine result |
| svc_req_i | input | NLANE | Service requests, one per lane |
| svc_gnt_o | output | NLANE | Service grants |
| eng_dout_i | input | NLANE*DW | Raw engine data per lane |
| eng_dout_o | output | NLANE*DW | Gated engine data per lane |
| key_clear_o | output | 1 | Request to zero the key store |
| st_pass_o | output | 1 | Self-tests passed, operating |
| st_err_o | output | 1 | Terminal fault |

## Verification
The bench models both engines with a configurable response delay, optional result corruption and an optional silence. It targets the timeout edge: an acknowledge in the last allowed cycle must pass, and silence must raise the fault exactly one cycle after that window. A design with an off-by-one counter would fault a valid late answer or wait one cycle too long. It also tests a trigger in the operating state, a trigger in the fault state and stray acknowledges carrying wrong data while operating. A design that left the fault on a trigger, failed to close the grants during a rerun, or trusted an acknowledge outside a test would show the wrong status or leak data. Randomised runs mix delays and failures on both engines to confirm that a failed encrypt test never leads to a decrypt request.

// File: rtl/stst_pkg.sv
package stst_pkg;

  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_ENC   = 3'd1,
    ST_DEC   = 3'd2,
    ST_OPER  = 3'd3,
    ST_ERROR = 3'd4
  } stst_state_e;

  // Next-state rule of the sequencer, kept apart so it reads as a table.
  function automatic stst_state_e stst_next(input stst_state_e cur,
                                            input logic trig,
                                            input logic ack,
                                            input logic match,
                                            input logic expired);
    stst_state_e nxt;
    nxt = cur;
    case (cur)
      ST_RESET: nxt = ST_ENC;
      ST_ENC: begin
        if (ack)          nxt = match ? ST_DEC : ST_ERROR;
        else if (expired) nxt = ST_ERROR;
      end
      ST_DEC: begin
        if (ack)          nxt = match ? ST_OPER : ST_ERROR;
        else if (expired) nxt = ST_ERROR;
      end
      ST_OPER:  if (trig) nxt = ST_ENC;
      ST_ERROR: nxt = ST_ERROR;
      default:  nxt = ST_ERROR;
    endcase
    return nxt;
  endfunction

  function automatic logic stst_in_test(input stst_state_e s);
    return (s == ST_ENC) || (s == ST_DEC);
  endfunction

endpackage

// File: rtl/stst_timer.sv
module stst_timer #(
  parameter int unsigned TIMEOUT = 32,
  localparam int unsigned CW = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic expired_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == CW'(TIMEOUT - 1));

endmodule

// File: rtl/stst_fsm.sv
module stst_fsm
  import stst_pkg::*;
#(
  parameter int unsigned BLK_W = 128,
  parameter logic [BLK_W-1:0] KAT_PT = '0,
  parameter logic [BLK_W-1:0] KAT_CT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             enc_ack_i,
  input  logic [BLK_W-1:0] enc_res_i,
  input  logic             dec_ack_i,
  input  logic [BLK_W-1:0] dec_res_i,
  input  logic             expired_i,
  output stst_state_e      state_o,
  output logic             restart_o,
  output logic             ev_pass_o,
  output logic             ev_fail_o,
  output logic             ev_timeout_o,
  output logic             ev_rerun_o
);

  stst_state_e state_q, state_d;
  logic             ack_cur;
  logic [BLK_W-1:0] res_cur;
  logic [BLK_W-1:0] exp_cur;
  logic             match;

  always_comb begin
    ack_cur = 1'b0;
    res_cur = '0;
    exp_cur = '0;
    case (state_q)
      ST_ENC: begin ack_cur = enc_ack_i; res_cur = enc_res_i; exp_cur = KAT_CT; end
      ST_DEC: begin ack_cur = dec_ack_i; res_cur = dec_res_i; exp_cur = KAT_PT; end
      default: ;
    endcase
  end

  assign match   = (res_cur == exp_cur);
  assign state_d = stst_next(state_q, trig_i, ack_cur, match, expired_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end

  assign state_o      = state_q;
  assign restart_o    = (state_d != state_q);
  assign ev_pass_o    = ack_cur && match;
  assign ev_fail_o    = ack_cur && !match;
  assign ev_timeout_o = stst_in_test(state_q) && !ack_cur && expired_i;
  assign ev_rerun_o   = (state_q == ST_OPER) && trig_i;

endmodule

// File: rtl/stst_gate.sv
module stst_gate #(
  parameter int unsigned NLANE = 2,
  parameter int unsigned DW    = 32
) (
  input  logic                open_i,
  input  logic [NLANE-1:0]    svc_req_i,
  output logic [NLANE-1:0]    svc_gnt_o,
  input  logic [NLANE*DW-1:0] dout_i,
  output logic [NLANE*DW-1:0] dout_o
);

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign svc_gnt_o[g]          = open_i & svc_req_i[g];
    assign dout_o[g*DW +: DW]    = open_i ? dout_i[g*DW +: DW] : '0;
  end

endmodule

// File: rtl/cipher_selftest_seq.sv
module cipher_selftest_seq
  import stst_pkg::*;
#(
  parameter int unsigned KEY_W   = 256,
  parameter int unsigned BLK_W   = 128,
  parameter int unsigned NLANE   = 2,
  parameter int unsigned DW      = 32,
  parameter int unsigned TIMEOUT = 32,
  parameter logic [KEY_W-1:0] KAT_KEY = {128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0,
                                         128'h00112233445566778899aabbccddeeff},
  parameter logic [BLK_W-1:0] KAT_TWEAK = 128'h13579bdf02468ace13579bdf02468ace,
  parameter logic [BLK_W-1:0] KAT_PT    = 128'hdeadbeef0123456789abcdeffedcba98,
  parameter logic [BLK_W-1:0] KAT_CT    = 128'h6c1f04a3b7e2995d08c4f13a72be5d10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                selftest_trig_i,
  output logic                kat_enc_req_o,
  output logic                kat_dec_req_o,
  output logic [KEY_W-1:0]    kat_key_o,
  output logic [BLK_W-1:0]    kat_tweak_o,
  output logic [BLK_W-1:0]    kat_din_o,
  input  logic                kat_enc_ack_i,
  input  logic [BLK_W-1:0]    kat_enc_res_i,
  input  logic                kat_dec_ack_i,
  input  logic [BLK_W-1:0]    kat_dec_res_i,
  input  logic [NLANE-1:0]    svc_req_i,
  output logic [NLANE-1:0]    svc_gnt_o,
  input  logic [NLANE*DW-1:0] eng_dout_i,
  output logic [NLANE*DW-1:0] eng_dout_o,
  output logic                key_clear_o,
  output logic                st_pass_o,
  output logic                st_err_o
);

  stst_state_e state;
  logic restart, expired, in_test;
  logic ev_pass, ev_fail, ev_timeout, ev_rerun;

  stst_fsm #(
    .BLK_W (BLK_W),
    .KAT_PT(KAT_PT),
    .KAT_CT(KAT_CT)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (selftest_trig_i),
    .enc_ack_i   (kat_enc_ack_i),
    .enc_res_i   (kat_enc_res_i),
    .dec_ack_i   (kat_dec_ack_i),
    .dec_res_i   (kat_dec_res_i),
    .expired_i   (expired),
    .state_o     (state),
    .restart_o   (restart),
    .ev_pass_o   (ev_pass),
    .ev_fail_o   (ev_fail),
    .ev_timeout_o(ev_timeout),
    .ev_rerun_o  (ev_rerun)
  );

  assign in_test = stst_in_test(state);

  stst_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (in_test),
    .restart_i(restart),
    .expired_o(expired)
  );

  stst_gate #(.NLANE(NLANE), .DW(DW)) u_gate (
    .open_i   (state == ST_OPER),
    .svc_req_i(svc_req_i),
    .svc_gnt_o(svc_gnt_o),
    .dout_i   (eng_dout_i),
    .dout_o   (eng_dout_o)
  );

  assign kat_enc_req_o = (state == ST_ENC);
  assign kat_dec_req_o = (state == ST_DEC);
  assign kat_key_o     = in_test ? KAT_KEY   : '0;
  assign kat_tweak_o   = in_test ? KAT_TWEAK : '0;
  assign kat_din_o     = (state == ST_ENC) ? KAT_PT :
                         (state == ST_DEC) ? KAT_CT : '0;
  assign key_clear_o   = (state == ST_ERROR);
  assign st_err_o      = (state == ST_ERROR);
  assign st_pass_o     = (state == ST_OPER);

endmodule

// File: rtl/stst_checker.sv
module stst_checker #(
  parameter int unsigned NLANE   = 2,
  parameter int unsigned DW      = 32,
  parameter int unsigned TIMEOUT = 32,
  localparam int unsigned RW = $clog2(TIMEOUT + 2)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                trig,
  input logic                enc_req,
  input logic                dec_req,
  input logic [NLANE-1:0]    gnt,
  input logic [NLANE*DW-1:0] dout,
  input logic                key_clear,
  input logic                pass,
  input logic                err,
  input logic                ev_pass,
  input logic                ev_fail,
  input logic                ev_timeout,
  input logic                ev_rerun
);

  logic          enc_q, dec_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_q <= 1'b0;
      dec_q <= 1'b0;
      run_q <= '0;
    end else begin
      enc_q <= enc_req;
      dec_q <= dec_req;
      if ((enc_req && enc_q) || (dec_req && dec_q)) run_q <= run_q + 1'b1;
      else                                          run_q <= '0;
    end
  end

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(enc_req && dec_req)); // R2
  AST_DEC_AFTER_ENC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_req) |-> $past(enc_req)); // R2
  AST_CLOSED_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !pass |-> (gnt == '0) && (dout == '0)); // R4
  AST_FAIL_TO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> err); // R5
  AST_ERR_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> key_clear && !enc_req && !dec_req && !pass); // R5
  AST_TIMEOUT_TO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> err); // R6
  AST_REQ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < RW'(TIMEOUT)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R7
  AST_TRIG_RERUN: assert property (@(posedge clk) disable iff (!rst_n)
    (pass && trig) |=> (enc_req && !pass)); // R8
  AST_RERUN_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rerun |=> enc_req); // R8
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && err)); // R9
  AST_PASS_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pass |=> (dec_req || pass)); // R2

endmodule

bind cipher_selftest_seq stst_checker #(
  .NLANE  (NLANE),
  .DW     (DW),
  .TIMEOUT(TIMEOUT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trig      (selftest_trig_i),
  .enc_req   (kat_enc_req_o),
  .dec_req   (kat_dec_req_o),
  .gnt       (svc_gnt_o),
  .dout      (eng_dout_o),
  .key_clear (key_clear_o),
  .pass      (st_pass_o),
  .err       (st_err_o),
  .ev_pass   (ev_pass),
  .ev_fail   (ev_fail),
  .ev_timeout(ev_timeout),
  .ev_rerun  (ev_rerun)
);

// File: tb/tb_cipher_selftest_seq.sv
module tb_cipher_selftest_seq;
  localparam int TO = 32;
  localparam int NL = 2;
  localparam int DW = 32;
  localparam int KW = 256;
  localparam int BW = 128;
  localparam logic [KW-1:0] T_KEY = {128'ha5a5a5a55a5a5a5a0123456789abcdef,
                                     128'hfedcba98765432100f0f0f0ff0f0f0f0};
  localparam logic [BW-1:0] T_TWK = 128'h11112222333344445555666677778888;
  localparam logic [BW-1:0] T_PT  = 128'h0badc0de0badc0de0badc0de0badc0de;
  localparam logic [BW-1:0] T_CT  = 128'h9e3779b97f4a7c15f39cc0605cedc834;

  logic clk, rst_n, trig;
  logic enc_req, dec_req, enc_ack, dec_ack;
  logic [KW-1:0] key;
  logic [BW-1:0] twk, din, enc_res, dec_res;
  logic [NL-1:0] svc_req, gnt;
  logic [NL*DW-1:0] dout_in, dout_out;
  logic key_clr, pass, err;

  cipher_selftest_seq #(
    .KEY_W(KW), .BLK_W(BW), .NLANE(NL), .DW(DW), .TIMEOUT(TO),
    .KAT_KEY(T_KEY), .KAT_TWEAK(T_TWK), .KAT_PT(T_PT), .KAT_CT(T_CT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .selftest_trig_i(trig),
    .kat_enc_req_o(enc_req), .kat_dec_req_o(dec_req),
    .kat_key_o(key), .kat_tweak_o(twk), .kat_din_o(din),
    .kat_enc_ack_i(enc_ack), .kat_enc_res_i(enc_res),
    .kat_dec_ack_i(dec_ack), .kat_dec_res_i(dec_res),
    .svc_req_i(svc_req), .svc_gnt_o(gnt),
    .eng_dout_i(dout_in), .eng_dout_o(dout_out),
    .key_clear_o(key_clr), .st_pass_o(pass), .st_err_o(err)
  );

  initial begin clk = 1'b0; forever #4 clk = ~clk; end

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [BW-1:0] act,
                     input logic [BW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Engine model configuration
  int e_dly = 0, d_dly = 0, e_w = 0, d_w = 0;
  bit e_bad = 0, d_bad = 0, e_mute = 0, d_mute = 0, spur = 0;
  bit e_seen = 0, d_seen = 0, order_err = 0, both_err = 0;

  initial begin
    enc_ack = 0; dec_ack = 0; enc_res = '0; dec_res = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        e_w = 0; d_w = 0; enc_ack = 0; dec_ack = 0;
      end else begin
        if (enc_req && dec_req) both_err = 1;
        if (dec_req && !e_seen) order_err = 1;
        if (enc_req) begin
          if (e_w == 0) begin
            e_seen = 1;
            chk(key == T_KEY && twk == T_TWK && din == T_PT, "R3 enc inputs", din, T_PT);
          end
          enc_ack = (!e_mute && e_w == e_dly);
          enc_res = e_bad ? (T_CT ^ 128'h1) : T_CT;
          e_w++;
        end else begin
          e_w = 0; enc_ack = spur; enc_res = spur ? ~T_CT : '0;
        end
        if (dec_req) begin
          if (d_w == 0) begin
            d_seen = 1;
            chk(key == T_KEY && twk == T_TWK && din == T_CT, "R3 dec inputs", din, T_CT);
          end
          dec_ack = (!d_mute && d_w == d_dly);
          dec_res = d_bad ? (T_PT ^ {1'b1, 127'h0}) : T_PT;
          d_w++;
        end else begin
          d_w = 0; dec_ack = spur; dec_res = spur ? ~T_PT : '0;
        end
      end
    end
  end

  function automatic bit exp_ok(input int dly, input bit bad, input bit mute);
    return !bad && !mute && (dly <= TO - 1);
  endfunction

  task automatic set_cfg(input int ed, input bit eb, input bit em,
                         input int dd, input bit db, input bit dm);
    e_dly = ed; e_bad = eb; e_mute = em; d_dly = dd; d_bad = db; d_mute = dm;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; trig = 1'b0;
    repeat (3) @(negedge clk);
    e_seen = 0; d_seen = 0; order_err = 0; both_err = 0;
  endtask

  task automatic check_outcome(input bit exp_pass, input string tag);
    logic [NL-1:0] sr;
    logic [NL*DW-1:0] dv;
    sr = NL'($urandom); dv = {$urandom, $urandom};
    svc_req = sr; dout_in = dv;
    #1;
    chk(pass == exp_pass, {tag, " R9 pass"}, BW'(pass), BW'(exp_pass));
    chk(err == !exp_pass, {tag, " R5 err"}, BW'(err), BW'(!exp_pass));
    chk(key_clr == !exp_pass, {tag, " R5 key_clear"}, BW'(key_clr), BW'(!exp_pass));
    chk(gnt == (exp_pass ? sr : '0), {tag, " R4 grant"}, BW'(gnt), BW'(exp_pass ? sr : '0));
    chk(dout_out == (exp_pass ? dv : '0), {tag, " R4 data"}, BW'(dout_out),
        BW'(exp_pass ? dv : '0));
  endtask

  task automatic run_case(input int ed, input bit eb, input bit em,
                          input int dd, input bit db, input bit dm, input string tag);
    bit eok, dok;
    do_reset();
    set_cfg(ed, eb, em, dd, db, dm);
    rst_n = 1'b1;
    repeat (2 * TO + 8) @(negedge clk);
    eok = exp_ok(ed, eb, em);
    dok = exp_ok(dd, db, dm);
    check_outcome(eok && dok, tag);
    chk(d_seen == eok, {tag, " R2 dec only after enc pass"}, BW'(d_seen), BW'(eok));
    chk(!order_err && !both_err, {tag, " R2 order"}, BW'({order_err, both_err}), '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rst_n = 1'b0; trig = 1'b0; svc_req = '1; dout_in = '1;
    set_cfg(3, 0, 0, 5, 0, 0);
    do_reset();
    svc_req = '1; dout_in = '1;
    #1;
    // Reset state
    chk(!pass && !err, "R9 reset status", BW'({pass, err}), '0);
    chk(!enc_req && !dec_req && !key_clr, "R5 reset reqs", BW'({enc_req, dec_req, key_clr}), '0);
    chk(gnt == '0 && dout_out == '0, "R4 reset gate", BW'(dout_out), '0);

    // R1: automatic start
    @(negedge clk); rst_n = 1'b1; #1;
    chk(!enc_req, "R1 no req before first edge", BW'(enc_req), '0);
    @(negedge clk); #1;
    chk(enc_req && !dec_req, "R1 enc starts", BW'({enc_req, dec_req}), BW'(2'b10));
    chk(gnt == '0 && dout_out == '0, "R4 blocked during test", BW'(dout_out), '0);
    repeat (2 * TO + 8) @(negedge clk);
    check_outcome(1'b1, "good");

    // R10: stray acks while operating
    spur = 1;
    repeat (5) @(negedge clk);
    spur = 0; #1;
    chk(pass && !err, "R10 stray ack ignored", BW'({pass, err}), BW'(2'b10));

    // R8: trigger rerun from operating
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0; #1;
    chk(!pass && enc_req, "R8 rerun starts", BW'({pass, enc_req}), BW'(2'b01));
    chk(gnt == '0, "R8 R4 traffic blocked on rerun", BW'(gnt), '0);
    repeat (2 * TO + 8) @(negedge clk);
    check_outcome(1'b1, "rerun");

    // R5: encrypt mismatch
    run_case(2, 1, 0, 2, 0, 0, "enc_bad");
    // R7: trigger ignored in fault
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    repeat (3) @(negedge clk); #1;
    chk(err && !enc_req && !pass, "R7 trigger ignored in fault",
        BW'({err, enc_req, pass}), BW'(3'b100));
    // R7: reset leaves the fault
    run_case(1, 0, 0, 1, 0, 0, "after_reset R7");

    // R5: decrypt mismatch
    run_case(4, 0, 0, 0, 1, 0, "dec_bad");
    // R6: last allowed cycle passes
    run_case(TO - 1, 0, 0, TO - 1, 0, 0, "edge R6");
    // R6: first late cycle fails
    run_case(TO, 0, 0, 0, 0, 0, "late R6");

    // R6: exact timeout cycle with a silent encrypt engine
    do_reset();
    set_cfg(0, 0, 1, 0, 0, 0);
    rst_n = 1'b1;
    repeat (TO) @(posedge clk);
    @(negedge clk); #1;
    chk(!err && enc_req, "R6 still waiting in last cycle", BW'({err, enc_req}), BW'(2'b01));
    @(negedge clk); #1;
    chk(err && key_clr, "R6 timeout fault", BW'({err, key_clr}), BW'(2'b11));

    // Random mix
    for (int i = 0; i < 40; i++) begin
      int ed, dd;
      bit eb, em, db, dm;
      ed = int'($urandom_range(0, TO + 1));
      dd = int'($urandom_range(0, TO + 1));
      eb = ($urandom % 5) == 0; em = ($urandom % 8) == 0;
      db = ($urandom % 5) == 0; dm = ($urandom % 8) == 0;
      run_case(ed, eb, em, dd, db, dm, "random R5 R6");
    end

    done = 1;
    summary();
  end

endmodule